// File: doc/BRIEF.md
# Serial-MAC Polyphase Interpolator by Two

This block doubles the sample rate of a slow stream of real samples. Each accepted 16-bit input sample (Q1.15) yields two 18-bit output samples (Q4.14). They come from the two polyphase branches of one FIR prototype whose taps are held in a parameter vector. The input rate is far below the clock rate, so each branch owns one multiplier. That multiplier steps through the branch's tap subset, one product per clock, and the accumulator keeps full precision.

The input stream is intended to arrive once per 32 clocks. After a sample is accepted, both branches run a 17-step multiply-accumulate sequence. The even-tap branch result leaves the block first. The odd-tap branch result leaves 16 clocks later, and the output phase flag tells them apart. The final cast takes the low 18 bits of the accumulator after an arithmetic right shift of 16. That gives floor rounding and wrap on overflow.

Top module: `interp2_serial_fir`

## Requirements
- R1: Synchronous active-low reset clears out_valid, out_phase, out_data and the whole sample history to zero, so the first outputs after reset depend only on samples accepted since reset.
- R2: For accepted sample x[n], the phase-0 output equals the sum over k = 0..16 of h[2k]·x[n−k], cast to the output format.
- R3: The phase-1 output for the same sample uses the odd taps: the sum over k = 0..16 of h[2k+1]·x[n−k], cast the same way.
- R4: The phase-0 result is signalled by a single-cycle out_valid with out_phase = 0, registered 17 clock edges after the edge that accepts the input.
- R5: The phase-1 result is signalled by a single-cycle out_valid with out_phase = 1, exactly 16 clocks after the phase-0 pulse; out_data keeps its value between pulses.
- R6: The cast to the output format rounds by floor: a negative full-precision sum with a fractional remainder moves toward minus infinity. For example, −1·30000 at Q30 gives −1 LSB, not 0.
- R7: Sums that exceed the 18-bit output range wrap modulo 2^18 and do not saturate.
- R8: in_valid may be raised only when no multiply-accumulate sequence is running, which means at least 18 clocks after the previous accepting edge. At that spacing the next sample is accepted while the previous phase-1 result is still pending, and both results of both samples come out correctly and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample, 15 fractional bits |
| out_valid | output | 1 | Output sample strobe, two pulses per input |
| out_phase | output | 1 | 0 for the even-tap branch result, 1 for the odd-tap branch result |
| out_data | output | 18 | Signed output sample, 14 fractional bits |

## Verification
Two events can fall in the same window: the delayed phase-1 emission of one sample, and the acceptance and multiply-accumulate run of the next sample. With inputs 18 clocks apart, the new sample is accepted and its run is under way when the previous sample's phase-1 pulse fires. The scoreboard pushes the expected phase, value and cycle of every output at the moment each input is accepted. Any corruption of the held odd-branch result, and any reordering or shift of a pulse in time, shows up as a miscompare against that queue.

// File: rtl/interp2_pkg.sv
// Package for the interpolate-by-two FIR.
// Holds the default geometry and a computed default tap set.
// Assumes an even tap count: taps split into two polyphase branches.
package interp2_pkg;

    localparam int DEF_DW    = 16;
    localparam int DEF_CW    = 16;
    localparam int DEF_NTAPS = 34;

    // Default prototype: a symmetric triangular shape scaled to fit Q1.15.
    function automatic logic [DEF_NTAPS*DEF_CW-1:0] default_taps();
        logic [DEF_NTAPS*DEF_CW-1:0] v;
        int mag;
        v = '0;
        for (int i = 0; i < DEF_NTAPS; i++) begin
            mag = (i < DEF_NTAPS/2) ? (i + 1) : (DEF_NTAPS - i);
            v[i*DEF_CW +: DEF_CW] = DEF_CW'(mag * 900);
        end
        return v;
    endfunction

endpackage

// File: rtl/interp2_seq.sv
// Sequencer for the serial multiply-accumulate.
// It accepts a sample when idle and then steps a tap index over the branch taps.
// It emits the phase-0 strobe at the last step and the phase-1 strobe OUT_GAP
// clocks later.
// Assumes the input is never strobed while a step sequence is running.
module interp2_seq #(
    parameter int TPP     = 17,
    parameter int OUT_GAP = 16,
    localparam int IDXW   = (TPP > 1) ? $clog2(TPP) : 1,
    localparam int GAPW   = (OUT_GAP > 1) ? $clog2(OUT_GAP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            load,
    output logic            step_en,
    output logic            first,
    output logic            last,
    output logic [IDXW-1:0] idx,
    output logic            out_valid,
    output logic            out_phase
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(TPP - 1);

    logic            busy;
    logic            pend;
    logic [GAPW-1:0] gap_cnt;
    logic            fire1;

    assign load    = in_valid && !busy;
    assign step_en = busy;
    assign first   = (idx == '0);
    assign last    = (idx == LAST_IDX);
    assign fire1   = pend && (gap_cnt == '0);

    // Run the tap index from zero to the last tap once per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (last) busy <= 1'b0;
            else      idx  <= idx + 1'b1;
        end
    end

    // Hold the phase-1 result back for OUT_GAP clocks after phase 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            gap_cnt <= '0;
        end else if (busy && last) begin
            pend    <= 1'b1;
            gap_cnt <= GAPW'(OUT_GAP - 1);
        end else if (pend) begin
            if (fire1) pend    <= 1'b0;
            else       gap_cnt <= gap_cnt - 1'b1;
        end
    end

    // Output strobe and branch select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_phase <= 1'b0;
        end else begin
            out_valid <= (busy && last) || fire1;
            if (busy && last) out_phase <= 1'b0;
            else if (fire1)   out_phase <= 1'b1;
        end
    end

    assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !busy)
        else $error("input strobe during a running sequence");

    assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy && first)
        else $error("sequence did not start at tap 0");

    assert_phase0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last) |=> (out_valid && !out_phase))
        else $error("phase-0 strobe missing after last step");

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid)
        else $error("output strobe longer than one cycle");
endmodule

// File: rtl/interp2_delay.sv
// Sample history for the interpolator: a shift register of TPP samples.
// Index 0 is the newest sample. The read port selects one entry per clock.
// Reset clears every entry to zero.
module interp2_delay #(
    parameter int DW     = 16,
    parameter int TPP    = 17,
    localparam int IDXW  = (TPP > 1) ? $clog2(TPP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DW-1:0]   din,
    input  logic [IDXW-1:0] rd_idx,
    output logic [DW-1:0]   rd_data
);
    logic [DW-1:0] taps [TPP];

    // Shift a newly accepted sample into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TPP; i++) taps[i] <= '0;
        end else if (load) begin
            taps[0] <= din;
            for (int i = 1; i < TPP; i++) taps[i] <= taps[i-1];
        end
    end

    // Select the entry addressed by the sequencer.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < TPP; i++)
            if (rd_idx == IDXW'(i)) rd_data = taps[i];
    end

    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> taps[0] == $past(din))
        else $error("history did not capture the accepted sample");
endmodule

// File: rtl/interp2_taps.sv
// Tap ROM: for tap index k it returns h[2k] for branch 0 and h[2k+1] for branch 1.
// The taps come from a flat parameter vector, least significant tap first.
module interp2_taps #(
    parameter int CW                 = 16,
    parameter int NTAPS              = 34,
    parameter logic [NTAPS*CW-1:0] TAPS = '0,
    localparam int TPP               = NTAPS / 2,
    localparam int IDXW              = (TPP > 1) ? $clog2(TPP) : 1
) (
    input  logic [IDXW-1:0]       idx,
    output logic [1:0][CW-1:0]    coef
);
    // Decode the tap index into the pair of branch taps.
    always_comb begin
        coef = '0;
        for (int i = 0; i < TPP; i++) begin
            if (idx == IDXW'(i)) begin
                coef[0] = TAPS[(2*i)*CW +: CW];
                coef[1] = TAPS[(2*i+1)*CW +: CW];
            end
        end
    end
endmodule

// File: rtl/interp2_mac.sv
// One polyphase branch: a single multiplier and a full-precision accumulator.
// At the last step it casts the sum (shift right by SHIFT, keep the low OW bits)
// into a result register. That register then holds until the next sequence ends.
module interp2_mac #(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int OW    = 18,
    parameter int TPP   = 17,
    parameter int SHIFT = 16,
    localparam int PW   = DW + CW,
    localparam int ACCW = PW + ((TPP > 1) ? $clog2(TPP) : 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          first,
    input  logic          last,
    input  logic [DW-1:0] sample,
    input  logic [CW-1:0] coef,
    output logic [OW-1:0] res
);
    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] sum_next;

    assign prod     = $signed(sample) * $signed(coef);
    assign sum_next = (first ? ACCW'(0) : acc) + ACCW'(prod);

    // Accumulate one product per step.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= '0;
        else if (step_en) acc <= sum_next;
    end

    // Floor and wrap the finished sum into the output format.
    always_ff @(posedge clk) begin
        if (!rst_n)                res <= '0;
        else if (step_en && last)  res <= OW'(sum_next >>> SHIFT);
    end

    assert_res_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_en && last) |=> $stable(res))
        else $error("branch result changed outside the last step");
endmodule

// File: rtl/interp2_serial_fir.sv
// Interpolate-by-two polyphase FIR with one time-shared multiplier per branch.
// Each accepted sample starts a TPP-step multiply-accumulate on both branches.
// The even branch result leaves first; the odd branch result leaves OUT_GAP clocks later.
// Assumes inputs are spaced at least TPP+1 clocks apart (nominally 32).
module interp2_serial_fir #(
    parameter int DW      = interp2_pkg::DEF_DW,
    parameter int CW      = interp2_pkg::DEF_CW,
    parameter int OW      = 18,
    parameter int DFRAC   = 15,
    parameter int CFRAC   = 15,
    parameter int OFRAC   = 14,
    parameter int NTAPS   = interp2_pkg::DEF_NTAPS,
    parameter int OUT_GAP = 16,
    parameter logic [NTAPS*CW-1:0] TAPS = interp2_pkg::default_taps()
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic          out_phase,
    output logic [OW-1:0] out_data
);
    localparam int TPP   = NTAPS / 2;
    localparam int IDXW  = (TPP > 1) ? $clog2(TPP) : 1;
    localparam int SHIFT = DFRAC + CFRAC - OFRAC;

    logic               load, step_en, first, last;
    logic [IDXW-1:0]    idx;
    logic [DW-1:0]      sample;
    logic [1:0][CW-1:0] coef;
    logic [OW-1:0]      res [2];

    interp2_seq #(.TPP(TPP), .OUT_GAP(OUT_GAP)) seq_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .load(load), .step_en(step_en), .first(first), .last(last),
        .idx(idx), .out_valid(out_valid), .out_phase(out_phase)
    );

    interp2_delay #(.DW(DW), .TPP(TPP)) hist_i (
        .clk(clk), .rst_n(rst_n), .load(load), .din(in_data),
        .rd_idx(idx), .rd_data(sample)
    );

    interp2_taps #(.CW(CW), .NTAPS(NTAPS), .TAPS(TAPS)) taps_i (
        .idx(idx), .coef(coef)
    );

    for (genvar p = 0; p < 2; p++) begin : g_branch
        interp2_mac #(.DW(DW), .CW(CW), .OW(OW), .TPP(TPP), .SHIFT(SHIFT)) mac_i (
            .clk(clk), .rst_n(rst_n), .step_en(step_en), .first(first),
            .last(last), .sample(sample), .coef(coef[p]), .res(res[p])
        );
    end

    // Present the result of the branch named by the phase flag.
    assign out_data = out_phase ? res[1] : res[0];
endmodule

// File: tb/interp2_serial_fir_tb.sv
module interp2_serial_fir_tb_top;
    localparam int NT = 34;

    function automatic int tap_val(input int i);
        return (i < 20) ? 30000 : ((i * 37) % 200) - 100;
    endfunction

    function automatic logic [NT*16-1:0] tb_taps();
        logic [NT*16-1:0] v;
        v = '0;
        for (int i = 0; i < NT; i++) v[i*16 +: 16] = 16'(tap_val(i));
        return v;
    endfunction

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic out_valid, out_phase;
    logic [17:0] out_data;

    interp2_serial_fir #(.TAPS(tb_taps())) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_phase(out_phase), .out_data(out_data)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit          ph;
        logic [17:0] d;
        longint      cyc;
        string       tag;
    } item_t;

    item_t  sb[$];
    int     checks = 0, fails = 0;
    longint cyc = 0;
    int     hist [17];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [17:0] model(input int p);
        longint s = 0;
        for (int k = 0; k < 17; k++) s += longint'(tap_val(2*k + p)) * longint'(hist[k]);
        return 18'(s >>> 16);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: present one sample, push its two expected results, then wait.
    task automatic send(input logic [15:0] x, input int gap, input string tag);
        item_t it;
        in_valid = 1'b1;
        in_data  = x;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 16; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'($signed(x));
        it.ph = 1'b0; it.d = model(0); it.cyc = cyc + 17; it.tag = tag;
        sb.push_back(it);
        it.ph = 1'b1; it.d = model(1); it.cyc = cyc + 33;
        sb.push_back(it);
        repeat (gap - 1) @(negedge clk);
    endtask

    // Monitor: compare every output pulse against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5", "unexpected pulse", 1, 0);
            end else begin
                item_t e;
                string rq;
                e = sb.pop_front();
                rq = e.ph ? "R3" : "R2";
                check(out_phase == e.ph, e.ph ? "R5" : "R4", "phase", out_phase, e.ph);
                check(cyc == e.cyc, e.ph ? "R5" : "R4", "cycle", cyc, e.cyc);
                check(out_data == e.d, {rq, "/", e.tag}, "data",
                      $signed(out_data), $signed(e.d));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 17; k++) hist[k] = 0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        check(out_data == '0, "R1", "reset out_data", out_data, 0);
        check(out_phase == 1'b0, "R1", "reset out_phase", out_phase, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first samples after reset see a zero history
        send(16'd16384, 32, "R1");
        send(16'hC000, 32, "R1");
        for (int i = 0; i < 6; i++) send(16'((i * 9173) % 65536 - 32768), 32, "R2");
        for (int i = 0; i < 17; i++) send(16'd0, 32, "R2");
        // R6: small negative sum must floor to -1
        send(16'hFFFF, 32, "R6");
        for (int i = 0; i < 3; i++) send(16'd0, 32, "R6");
        // R7: sustained full-scale input overflows and wraps
        for (int i = 0; i < 12; i++) send(16'h7FFF, 32, "R7");
        for (int i = 0; i < 12; i++) send(16'h8000, 32, "R7");
        // R8: minimum legal spacing overlaps phase-1 emission with the next run
        for (int i = 0; i < 8; i++) send(16'((i * 4099) % 65536 - 20000), 18, "R8");
        repeat (60) @(negedge clk);
        check(sb.size() == 0, "R5", "outputs still missing", sb.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule